// File: doc/BRIEF.md
# SPI Master Word Transfer Engine

This block is a single-lane SPI master driven by one 32-bit command word. Software writes the command word to set the clock mode, the divider, the chip-select line and how it is driven, the bit and byte order, the word length, and whether transmit and receive are enabled. A write that also carries the start bit, with the master bit set, shifts one word out of the transmit word input on `mosi` and assembles one word from `miso`. It then pushes that word to the receive output and raises a ready flag that software clears by a write-one strobe.

The serial clock runs at the system clock divided by 2*(DIV+1). In hardware chip-select mode the selected line is asserted for the whole transfer, with a setup and hold margin around the clock edges. In software mode a command bit drives the selected line directly. Command writes that arrive while a transfer is in flight are dropped.

Top module: `spi_word_engine`

## Requirements
- R1: Writing the command word with bit 31 (start) and bit 30 (master) both set starts one transfer. When the transfer ends, bit 31 of the command readback reads 0. A write with bit 31 set and bit 30 clear starts nothing and stores bit 31 as 0.
- R2: Bits 4:0 hold the word length minus one. A transfer produces exactly 2*(LEN+1) `sclk` edges, so 7 gives 8 bits and 31 gives 32 bits.
- R3: Bit 29 is CPOL and bit 28 is CPHA. `sclk` rests at the CPOL level outside the shift phase. With CPHA=0 `miso` is sampled on leading edges and `mosi` changes only on trailing edges. With CPHA=1 `mosi` changes only on leading edges and sampling is on trailing edges.
- R4: Bits 10:6 hold DIV. Every `sclk` half period lasts DIV+1 system clocks.
- R5: Bit 16 clear sends word bit LEN first and bit 0 last. Bit 16 set sends bit 0 first. The k-th sampled `miso` bit lands at the same word position as the k-th transmitted bit.
- R6: Bit 15 set reverses the four bytes of the 32-bit word, both before transmission and after reception. The length then counts from bit 0 of the swapped word.
- R7: Bit 21 clear (hardware chip select): the line chosen by bits 27:26 is active from at least DIV+1 clocks before the first `sclk` edge until at least DIV+1 clocks after the last one. All other lines stay inactive.
- R8: Bit 21 set (software chip select): bit 20 drives the selected line, 0 active and 1 inactive, with or without a transfer.
- R9: Bit 22 set inverts line 0, so its inactive level becomes 0 and its active level becomes 1. Lines 1 to 3 are active low.
- R10: Bit 11 clear (transmit off): `mosi` holds the idle level from bit 18 for the whole transfer. Bit 12 clear (receive off): no `rxValid` pulse occurs and `rxWord` keeps its previous value. With bit 12 set, one `rxValid` pulse comes with the new word.
- R11: `stsReady` rises when a transfer completes and falls after a cycle with `stsClrRdy` high. If completion and the clear fall in the same cycle, completion wins.
- R12: A command write during a transfer has no effect. The command readback and the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWrData | input | 32 | Command word to write |
| cmdRdData | output | 32 | Command word readback |
| stsClrRdy | input | 1 | Write-one clear of the ready flag |
| stsReady | output | 1 | Transfer complete flag |
| txWord | input | 32 | Transmit word, captured with the start write |
| rxWord | output | 32 | Last received word |
| rxValid | output | 1 | One-cycle pulse when `rxWord` is updated |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Chip-select lines |

## Verification
The ready flag's set on completion and its clear strobe can land in the same system clock. The bench holds `stsClrRdy` high from the start write through the whole transfer, so the clear is present on the completion edge. The flag must then be seen high at the next sample, and it must stay high once the strobe drops. A second overlap, a command write arriving in the middle of a shift, is judged from the readback and from the edge count of the running transfer.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam int CMD_W    = 32;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 5;
  localparam int DIV_W    = 5;
  localparam int CS_W     = 2;
  localparam int NUM_CS   = 1 << CS_W;
  localparam int CNT_W    = LEN_W + 1;
  localparam int PH_W     = LEN_W + 1;

  localparam int B_GO     = 31;
  localparam int B_MASTER = 30;
  localparam int B_CPOL   = 29;
  localparam int B_CPHA   = 28;
  localparam int B_CSSEL  = 26;
  localparam int B_CS0POL = 22;
  localparam int B_SWCS   = 21;
  localparam int B_SWLVL  = 20;
  localparam int B_IDLE   = 18;
  localparam int B_LSB    = 16;
  localparam int B_BSWAP  = 15;
  localparam int B_RXEN   = 12;
  localparam int B_TXEN   = 11;
  localparam int B_DIV    = 6;
  localparam int B_LEN    = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD} engState_t;

  typedef struct packed {
    logic active;
    logic load;
    logic advance;
    logic sample;
    logic finish;
  } engStrobe_t;

  typedef struct packed {
    logic             lsbFirst;
    logic             byteSwap;
    logic             txEn;
    logic             rxEn;
    logic             idleLvl;
    logic [LEN_W-1:0] len;
  } dpCfg_t;

  function automatic logic [WORD_W-1:0] swapBytes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W / 8; b++) begin
      r[b*8 +: 8] = w[(WORD_W/8 - 1 - b)*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl
  import spi_word_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrData,
  input  logic              stsClrRdy,
  output logic [CMD_W-1:0]  cmdReg,
  output logic              stsReady,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN,
  output engStrobe_t        strobe
);
  engState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  ph;
  logic             sclkReg;

  logic [DIV_W-1:0] divVal;
  logic [LEN_W-1:0] lenVal;
  logic [PH_W-1:0]  lastPh;
  logic             tick, accept, startGo, done, shiftTick, isLead, lastEdge, cpha;
  logic             busy, csOn;
  logic [CS_W-1:0]  csSel;

  assign divVal    = cmdReg[B_DIV +: DIV_W];
  assign lenVal    = cmdReg[B_LEN +: LEN_W];
  assign lastPh    = {lenVal, 1'b1};
  assign cpha      = cmdReg[B_CPHA];
  assign busy      = (state != ST_IDLE);
  assign tick      = (divCnt == divVal);
  assign accept    = (state == ST_IDLE) && cmdWrEn;
  assign startGo   = accept && cmdWrData[B_GO] && cmdWrData[B_MASTER];
  assign done      = (state == ST_HOLD) && tick;
  assign shiftTick = (state == ST_SHIFT) && tick;
  assign isLead    = ~ph[0];
  assign lastEdge  = (ph == lastPh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cmdReg   <= '0;
      divCnt   <= '0;
      ph       <= '0;
      sclkReg  <= 1'b0;
      stsReady <= 1'b0;
    end else begin
      stsReady <= done | (stsReady & ~stsClrRdy);
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cmdReg <= startGo ? cmdWrData : {1'b0, cmdWrData[CMD_W-2:0]};
          end
          if (startGo) begin
            state   <= ST_SETUP;
            divCnt  <= '0;
            sclkReg <= cmdWrData[B_CPOL];
          end
        end
        ST_SETUP: begin
          if (tick) begin
            divCnt <= '0;
            ph     <= '0;
            state  <= ST_SHIFT;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt  <= '0;
            sclkReg <= ~sclkReg;
            if (lastEdge) state <= ST_HOLD;
            else          ph    <= ph + 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            divCnt       <= '0;
            state        <= ST_IDLE;
            cmdReg[B_GO] <= 1'b0;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk = busy ? sclkReg : cmdReg[B_CPOL];

  always_comb begin
    strobe.active  = busy;
    strobe.load    = startGo;
    strobe.sample  = shiftTick && (isLead ^ cpha);
    strobe.advance = shiftTick && !(isLead ^ cpha) && (ph != '0) && !lastEdge;
    strobe.finish  = done;
  end

  assign csSel = cmdReg[B_CSSEL +: CS_W];
  assign csOn  = cmdReg[B_SWCS] ? ~cmdReg[B_SWLVL] : busy;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    logic lvl;
    assign lvl = ~(csOn && (csSel == CS_W'(i)));
    if (i == 0) begin : g_pol
      assign csN[i] = lvl ^ cmdReg[B_CS0POL];
    end else begin : g_plain
      assign csN[i] = lvl;
    end
  end

  // R11
  ready_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> stsReady);
  // R1
  go_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !cmdReg[B_GO]);
  // R12
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && cmdWrEn) |=> (cmdReg == $past(cmdReg)));
  // R3
  sclk_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> (sclkReg == cmdReg[B_CPOL]));
endmodule

// File: rtl/spi_word_dpath.sv
module spi_word_dpath
  import spi_word_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strobe,
  input  dpCfg_t            cfg,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);
  logic [WORD_W-1:0] txRaw;
  logic [WORD_W-1:0] rxAcc;
  logic [CNT_W-1:0]  outCnt;
  logic [CNT_W-1:0]  inCnt;
  logic [LEN_W-1:0]  oIdx, iIdx, oMap;

  assign oIdx = cfg.lsbFirst ? outCnt[LEN_W-1:0] : cfg.len - outCnt[LEN_W-1:0];
  assign iIdx = cfg.lsbFirst ? inCnt[LEN_W-1:0]  : cfg.len - inCnt[LEN_W-1:0];
  assign oMap = cfg.byteSwap ? {~oIdx[LEN_W-1:3], oIdx[2:0]} : oIdx;
  assign mosi = (strobe.active && cfg.txEn) ? txRaw[oMap] : cfg.idleLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txRaw   <= '0;
      rxAcc   <= '0;
      outCnt  <= '0;
      inCnt   <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strobe.finish && cfg.rxEn;
      if (strobe.load) begin
        txRaw  <= txWord;
        rxAcc  <= '0;
        outCnt <= '0;
        inCnt  <= '0;
      end
      if (strobe.advance) outCnt <= outCnt + 1'b1;
      if (strobe.sample) begin
        rxAcc[iIdx] <= miso;
        inCnt       <= inCnt + 1'b1;
      end
      if (strobe.finish && cfg.rxEn) begin
        rxWord <= cfg.byteSwap ? swapBytes(rxAcc) : rxAcc;
      end
    end
  end

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |-> (inCnt == ({1'b0, cfg.len} + 1'b1)));
  // R10
  no_rx_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !cfg.rxEn) |=> !rxValid);
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_word_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [31:0] cmdWrData,
  output logic [31:0] cmdRdData,
  input  logic        stsClrRdy,
  output logic        stsReady,
  input  logic [31:0] txWord,
  output logic [31:0] rxWord,
  output logic        rxValid,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  csN
);
  logic [CMD_W-1:0] cmdReg;
  engStrobe_t       strobe;
  dpCfg_t           cfg;

  assign cmdRdData    = cmdReg;
  assign cfg.lsbFirst = cmdReg[B_LSB];
  assign cfg.byteSwap = cmdReg[B_BSWAP];
  assign cfg.txEn     = cmdReg[B_TXEN];
  assign cfg.rxEn     = cmdReg[B_RXEN];
  assign cfg.idleLvl  = cmdReg[B_IDLE];
  assign cfg.len      = cmdReg[B_LEN +: LEN_W];

  spi_word_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWrEn   (cmdWrEn),
    .cmdWrData (cmdWrData),
    .stsClrRdy (stsClrRdy),
    .cmdReg    (cmdReg),
    .stsReady  (stsReady),
    .sclk      (sclk),
    .csN       (csN),
    .strobe    (strobe)
  );

  spi_word_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfg     (cfg),
    .txWord  (txWord),
    .miso    (miso),
    .mosi    (mosi),
    .rxWord  (rxWord),
    .rxValid (rxValid)
  );
endmodule

// File: tb/spi_word_engine_tb.sv
module spi_word_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic [31:0] cmdRdData;
  logic        stsClrRdy = 1'b0;
  logic        stsReady;
  logic [31:0] txWord = '0;
  logic [31:0] rxWord;
  logic        rxValid;
  logic        sclk;
  logic        mosi;
  logic        miso = 1'b0;
  logic [3:0]  csN;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_word_engine dut_i (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .stsClrRdy(stsClrRdy), .stsReady(stsReady),
    .txWord(txWord), .rxWord(rxWord), .rxValid(rxValid), .sclk(sclk),
    .mosi(mosi), .miso(miso), .csN(csN)
  );

  // monitor state
  logic        monOn = 1'b0;
  logic        monCpol, monCpha, monPol, prevSclk;
  int          monSel, monH;
  int          nEdges, nS, gapCnt, gapBad, setupCnt, holdCnt, otherBad, rxPulses;
  logic [31:0] seenBits, slaveWord;

  function automatic logic [31:0] bsw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic idleOf(input int i, input logic pol);
    return (i == 0 && pol) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [31:0] mkCmd(input bit go, input bit mst, input int mode,
      input int sel, input bit pol, input bit swcs, input bit swlvl, input bit idle,
      input bit lsb, input bit swp, input bit rxen, input bit txen, input int dv, input int len);
    logic [31:0] c;
    c = '0;
    c[31] = go; c[30] = mst; c[29:28] = mode[1:0]; c[27:26] = sel[1:0];
    c[22] = pol; c[21] = swcs; c[20] = swlvl; c[18] = idle; c[16] = lsb;
    c[15] = swp; c[12] = rxen; c[11] = txen; c[10:6] = dv[4:0]; c[4:0] = len[4:0];
    return c;
  endfunction

  always @(negedge clk) begin
    if (rxValid) rxPulses++;
    if (monOn) begin
      for (int i = 0; i < 4; i++) begin
        if (i != monSel && csN[i] !== idleOf(i, monPol)) otherBad++;
      end
      if (sclk !== prevSclk) begin
        if (nEdges > 0 && gapCnt + 1 != monH) gapBad++;
        gapCnt = 0;
        holdCnt = 0;
        if ((prevSclk == monCpol) != monCpha) begin
          if (nS < 32) seenBits[nS] = mosi;
          nS++;
          if (nS < 32) miso = slaveWord[31 - nS];
        end
        nEdges++;
      end else begin
        gapCnt++;
        if (csN[monSel] === ~idleOf(monSel, monPol)) begin
          if (nEdges == 0) setupCnt++;
          else holdCnt++;
        end
      end
      prevSclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeCmd(input logic [31:0] c, input logic [31:0] tx);
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWrData = c; txWord = tx;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic runXfer(input string tag, input logic [31:0] cmd, input logic [31:0] tx,
                         input logic [31:0] slv, input bit intrude, input bit holdClr);
    int L, H;
    bit gotRdy;
    logic [31:0] txEff, expMosi, acc, expRx, mask, oldRx;
    L = int'(cmd[4:0]) + 1;
    H = int'(cmd[10:6]) + 1;
    writeCmd({1'b0, cmd[30:0]}, tx);
    chk(sclk == cmd[29], "R3", "sclk rest level", {31'b0, sclk}, {31'b0, cmd[29]});
    monCpol = cmd[29]; monCpha = cmd[28]; monPol = cmd[22]; monSel = int'(cmd[27:26]);
    monH = H; nEdges = 0; nS = 0; gapCnt = 0; gapBad = 0; setupCnt = 0; holdCnt = 0;
    otherBad = 0; rxPulses = 0; seenBits = '0; slaveWord = slv; miso = slv[31];
    prevSclk = sclk; oldRx = rxWord;
    monOn = 1'b1;
    if (holdClr) stsClrRdy = 1'b1;
    writeCmd(cmd, tx);
    if (intrude) begin
      repeat (5) @(negedge clk);
      cmdWrEn = 1'b1; cmdWrData = mkCmd(1, 1, 3, 3, 0, 1, 0, 1, 1, 1, 1, 1, 0, 31);
      @(negedge clk);
      cmdWrEn = 1'b0;
      chk(cmdRdData == cmd, "R12", "readback after busy write", cmdRdData, cmd);
    end
    gotRdy = 0;
    for (int w = 0; w < 20000 && !gotRdy; w++) begin
      if (stsReady) gotRdy = 1;
      else @(negedge clk);
    end
    stsClrRdy = 1'b0;
    chk(gotRdy, "R11", "ready after completion", {31'b0, stsReady}, 32'd1);
    repeat (3) @(negedge clk);
    monOn = 1'b0;
    chk(stsReady, "R11", "ready held after clear released", {31'b0, stsReady}, 32'd1);
    chk(cmdRdData[31] == 1'b0, "R1", "start bit cleared", cmdRdData, {1'b0, cmd[30:0]});
    chk(nEdges == 2 * L, "R2", "sclk edge count", nEdges, 2 * L);
    chk(sclk == cmd[29], "R3", "sclk back at rest", {31'b0, sclk}, {31'b0, cmd[29]});
    chk(gapBad == 0, "R4", "half period length", gapBad, 0);
    mask = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 1);
    txEff = cmd[15] ? bsw(tx) : tx;
    expMosi = '0;
    acc = '0;
    for (int k = 0; k < L; k++) begin
      int idx;
      idx = cmd[16] ? k : L - 1 - k;
      expMosi[k] = cmd[11] ? txEff[idx] : cmd[18];
      acc[idx] = slv[31 - k];
    end
    chk((seenBits & mask) == expMosi, tag, "mosi bit sequence", seenBits & mask, expMosi);
    expRx = cmd[15] ? bsw(acc) : acc;
    if (cmd[12]) begin
      chk(rxWord == expRx, tag, "received word", rxWord, expRx);
      chk(rxPulses == 1, "R10", "one rx push", rxPulses, 1);
    end else begin
      chk(rxWord == oldRx, "R10", "rx word kept", rxWord, oldRx);
      chk(rxPulses == 0, "R10", "no rx push", rxPulses, 0);
    end
    chk(otherBad == 0, "R7", "unselected lines inactive", otherBad, 0);
    if (!cmd[21]) begin
      chk(setupCnt >= H, "R7", "cs setup cycles", setupCnt, H);
      chk(holdCnt + 1 >= H, "R7", "cs hold cycles", holdCnt + 1, H);
    end
    @(negedge clk); stsClrRdy = 1'b1;
    @(negedge clk); stsClrRdy = 1'b0;
    chk(!stsReady, "R11", "ready cleared", {31'b0, stsReady}, 32'd0);
  endtask

  task automatic t_reset();
    chk(stsReady == 1'b0, "R11", "reset ready", {31'b0, stsReady}, 0);
    chk(csN == 4'hF, "R7", "reset cs lines", {28'b0, csN}, 32'hF);
    chk(cmdRdData == 32'h0, "R1", "reset command", cmdRdData, 0);
    chk(sclk == 1'b0 && rxValid == 1'b0, "R3", "reset sclk and rxValid", {30'b0, sclk, rxValid}, 0);
  endtask

  task automatic t_mode0_msb();
    runXfer("R5", mkCmd(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 7), 32'h5A3C_81C3, 32'hB400_0000, 0, 0);
  endtask

  task automatic t_mode3_lsb();
    runXfer("R5", mkCmd(1, 1, 3, 2, 0, 0, 0, 0, 1, 0, 1, 1, 0, 31), 32'h1234_5678, 32'hCAFE_F00D, 0, 0);
  endtask

  task automatic t_mode1_swap();
    runXfer("R6", mkCmd(1, 1, 1, 3, 0, 0, 0, 0, 0, 1, 1, 1, 2, 15), 32'h1122_A55A, 32'h9D30_0000, 0, 0);
  endtask

  task automatic t_mode2_cs0pol();
    // R9: line 0 selected with inverted polarity, LSB first and byte swap together
    runXfer("R6", mkCmd(1, 1, 2, 0, 1, 0, 0, 0, 1, 1, 1, 1, 3, 23), 32'hF0E1_D2C3, 32'h6B5A_4900, 0, 0);
  endtask

  task automatic t_disabled();
    runXfer("R10", mkCmd(1, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 11), 32'h0000_0000, 32'hFFFF_FFFF, 0, 0);
  endtask

  task automatic t_busy_write();
    runXfer("R12", mkCmd(1, 1, 0, 2, 0, 0, 0, 0, 0, 0, 1, 1, 2, 7), 32'h0000_0096, 32'h3C00_0000, 1, 0);
  endtask

  task automatic t_collide();
    runXfer("R11", mkCmd(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 3), 32'h0000_000A, 32'h5000_0000, 0, 1);
  endtask

  task automatic t_swcs();
    writeCmd(mkCmd(0, 1, 0, 2, 0, 1, 0, 0, 0, 0, 0, 0, 0, 7), '0);
    chk(csN == 4'b1011, "R8", "software cs active", {28'b0, csN}, 32'hB);
    writeCmd(mkCmd(0, 1, 0, 2, 0, 1, 1, 0, 0, 0, 0, 0, 0, 7), '0);
    chk(csN == 4'b1111, "R8", "software cs inactive", {28'b0, csN}, 32'hF);
    writeCmd(mkCmd(0, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 7), '0);
    chk(csN == 4'b1100, "R9", "line 0 inverted idle", {28'b0, csN}, 32'hC);
    writeCmd(mkCmd(0, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 7), '0);
    chk(csN == 4'b1111, "R9", "line 0 inverted active", {28'b0, csN}, 32'hF);
    writeCmd(mkCmd(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7), '0);
  endtask

  task automatic t_no_master();
    int toggles;
    logic s0;
    toggles = 0;
    s0 = sclk;
    writeCmd(mkCmd(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 7), 32'hFF);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk !== s0) toggles++;
    end
    chk(toggles == 0 && !stsReady, "R1", "no transfer without master", {31'b0, stsReady} | toggles, 0);
    chk(cmdRdData[31] == 1'b0, "R1", "start bit not stored", cmdRdData, {1'b0, cmdRdData[30:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_msb();
    t_mode3_lsb();
    t_mode1_swap();
    t_mode2_cs0pol();
    t_disabled();
    t_busy_write();
    t_collide();
    t_swcs();
    t_no_master();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule